// File: doc/BRIEF.md
# Floating-Point Control Register with Rounding and Accuracy Mode Checks

This block keeps the floating-point control and status word for one core. The word has three fields: five sticky exception flags, a three-bit rounding mode and a three-bit accuracy mode. The accuracy mode tells the arithmetic units how much error a result may carry. The block changes neither operand nor result formats. It only forwards the accuracy mode as a hint. Software reaches the word through one CSR port. A view selector chooses whether the port sees the whole word, only the rounding field or only the flags. The arithmetic units OR their exception flags into the word as operations retire.

For each decoded floating-point instruction, the block works out which rounding mode and which accuracy mode apply. Within the same cycle it also decides whether the instruction must take an illegal-instruction trap. A trap has two causes:
- the instruction asks for the dynamic rounding mode while the stored mode is invalid;
- the stored accuracy mode is not supported for the instruction's operation class.

The second trap lets software emulate the missing mode. A configuration mask lists the supported modes, one bit per class and accuracy encoding. The `PROMOTE` parameter selects how an unsupported mode is handled. With `PROMOTE` = 1, a request is served by a more accurate supported mode where one exists, instead of trapping.

Top module: `fpctl_unit`

## Requirements
- R1: After reset, the flags, rounding and accuracy fields are all zero. Accuracy 000 is the correctly rounded default mode.
- R2: View 2'b00 reads and writes the whole word, with these field positions:
  - flags in bits 4..0;
  - rounding in bits 7..5;
  - accuracy in bits 10..8.

  Bits 31..11 read as zero and ignore writes.
- R3: View 2'b01 reads the rounding field in bits 2..0, with zeros above. A write through this view changes only the rounding field.
- R4: View 2'b10 reads the flags in bits 4..0, with zeros above. A write through this view changes only the flags.
- R5: When `flag_valid` is high in a cycle, `flag_bits` are ORed into the stored flags at the next clock edge.
- R6: A CSR write that reaches the flags (view 2'b00 or 2'b10) in the same cycle as an accumulation wins, and the accumulated bits are lost. A rounding-only write does not block accumulation.
- R7: An instruction rm of 3'b111 makes `eff_rm` equal the stored rounding field. Any other rm value passes through unchanged as a static mode.
- R8: A valid instruction with rm 3'b111 traps when the stored rounding field is 101, 110 or 111. Static rm values never trap on the rounding check.
- R9: The even accuracy encodings are:
  - 000: correctly rounded;
  - 010: error below 1 ULP;
  - 100: graphics-API accuracy;
  - 110: approximate machine-learning accuracy.

  Mode `a` is supported for class `c` when `acc_support_mask[c*8+a]` is 1. With `PROMOTE` = 0, a valid instruction traps when its mode is unsupported.
- R10: An odd accuracy encoding (001, 011, 101, 111) traps for every class, whatever the mask holds.
- R11: With `PROMOTE` = 1, an unsupported even mode is served by the nearest supported mode of lower encoding, which is more accurate, and `eff_acc` shows that mode. The instruction traps only when no such mode exists.
- R12: `trap` is combinational with the decode inputs and is low whenever `dec_valid` is low. With `PROMOTE` = 0, `eff_acc` equals the stored accuracy field.
- R13: View 2'b11 reads as zero, and a write through it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | CSR write strobe |
| csr_view | input | 2 | View select: 00 whole, 01 rounding, 10 flags, 11 none |
| csr_wdata | input | 32 | CSR write data, aligned to the selected view |
| csr_rdata | output | 32 | CSR read data for the selected view |
| flag_valid | input | 1 | A retiring operation delivers exception flags |
| flag_bits | input | 5 | Exception flags to accumulate |
| dec_valid | input | 1 | A floating-point instruction is being decoded |
| dec_rm | input | 3 | Rounding-mode field of the instruction |
| dec_cls | input | CLS_W | Operation class of the instruction |
| acc_support_mask | input | NUM_CLASSES*8 | Supported accuracy modes, 8 bits per class |
| eff_rm | output | 3 | Rounding mode that applies |
| eff_acc | output | 3 | Accuracy mode handed to the datapath |
| trap | output | 1 | Illegal-instruction trap request |

## Verification
The bench builds two copies with four operation classes. One uses `PROMOTE` = 0 and the other `PROMOTE` = 1. Both share the CSR and decode stimulus, but each has its own support mask. The non-promoting copy sweeps every class against all eight accuracy encodings. Its mask sets an odd-encoding bit on purpose, to show that the bit is ignored. The promoting copy's mask includes a class that lacks the default mode. That class brings the case of no available fallback within reach, along with fallbacks of one and two steps.

// File: rtl/fpctl_pkg.sv
package fpctl_pkg;
  localparam int CSR_W     = 32;
  localparam int FLAG_W    = 5;
  localparam int RM_W      = 3;
  localparam int ACC_W     = 3;
  localparam int FLAG_LSB  = 0;
  localparam int RM_LSB    = FLAG_LSB + FLAG_W;
  localparam int ACC_LSB   = RM_LSB + RM_W;
  localparam int USED_W    = ACC_LSB + ACC_W;
  localparam int ACC_CODES = 1 << ACC_W;
  localparam int ACC_EVEN  = ACC_CODES / 2;

  localparam logic [RM_W-1:0] RM_DYNAMIC  = 3'b111;
  localparam logic [RM_W-1:0] RM_LAST_OK  = 3'b100;

  typedef enum logic [1:0] {
    VIEW_WHOLE = 2'b00,
    VIEW_ROUND = 2'b01,
    VIEW_FLAGS = 2'b10,
    VIEW_NONE  = 2'b11
  } csr_view_e;
endpackage

// File: rtl/fpctl_regs.sv
module fpctl_regs
  import fpctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  csr_view_e         csr_view,
  input  logic [CSR_W-1:0]  csr_wdata,
  input  logic              flag_valid,
  input  logic [FLAG_W-1:0] flag_bits,
  output logic [FLAG_W-1:0] flags_q,
  output logic [RM_W-1:0]   frm_q,
  output logic [ACC_W-1:0]  acc_q,
  output logic [CSR_W-1:0]  csr_rdata
);
  logic [FLAG_W-1:0] flags_d;
  logic [RM_W-1:0]   frm_d;
  logic [ACC_W-1:0]  acc_d;
  logic              flags_en, frm_en, acc_en;
  logic              wr_whole, wr_round, wr_flags;
  logic [CSR_W-USED_W-1:0] unused_wr_hi;

  assign unused_wr_hi = csr_wdata[CSR_W-1:USED_W];

  always_comb begin
    wr_whole = csr_we && (csr_view == VIEW_WHOLE);
    wr_round = csr_we && (csr_view == VIEW_ROUND);
    wr_flags = csr_we && (csr_view == VIEW_FLAGS);

    flags_d  = flags_q;
    flags_en = 1'b0;
    if (wr_whole) begin
      flags_d  = csr_wdata[FLAG_LSB +: FLAG_W];
      flags_en = 1'b1;
    end else if (wr_flags) begin
      flags_d  = csr_wdata[FLAG_W-1:0];
      flags_en = 1'b1;
    end else if (flag_valid) begin
      flags_d  = flags_q | flag_bits;
      flags_en = 1'b1;
    end

    frm_d  = frm_q;
    frm_en = 1'b0;
    if (wr_whole) begin
      frm_d  = csr_wdata[RM_LSB +: RM_W];
      frm_en = 1'b1;
    end else if (wr_round) begin
      frm_d  = csr_wdata[RM_W-1:0];
      frm_en = 1'b1;
    end

    acc_en = wr_whole;
    acc_d  = wr_whole ? csr_wdata[ACC_LSB +: ACC_W] : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      frm_q   <= '0;
      acc_q   <= '0;
    end else begin
      if (flags_en) flags_q <= flags_d;
      if (frm_en)   frm_q   <= frm_d;
      if (acc_en)   acc_q   <= acc_d;
    end
  end

  always_comb begin
    csr_rdata = '0;
    unique case (csr_view)
      VIEW_WHOLE: begin
        csr_rdata[FLAG_LSB +: FLAG_W] = flags_q;
        csr_rdata[RM_LSB +: RM_W]     = frm_q;
        csr_rdata[ACC_LSB +: ACC_W]   = acc_q;
      end
      VIEW_ROUND: csr_rdata[RM_W-1:0]   = frm_q;
      VIEW_FLAGS: csr_rdata[FLAG_W-1:0] = flags_q;
      default:    csr_rdata = '0;
    endcase
  end

  assert_flag_accum_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_valid && !wr_whole && !wr_flags) |=>
      flags_q == ($past(flags_q) | $past(flag_bits)));

  assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flags |=> flags_q == $past(csr_wdata[FLAG_W-1:0]));

  assert_acc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_whole |=> $stable(acc_q));

  assert_round_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_round && !flag_valid) |=> ($stable(flags_q) && $stable(acc_q)));
endmodule

// File: rtl/fpctl_round_sel.sv
module fpctl_round_sel
  import fpctl_pkg::*;
(
  input  logic [RM_W-1:0] dec_rm,
  input  logic [RM_W-1:0] frm_q,
  output logic [RM_W-1:0] eff_rm,
  output logic            rm_bad
);
  logic dyn_sel;

  always_comb begin
    dyn_sel = (dec_rm == RM_DYNAMIC);
    eff_rm  = dyn_sel ? frm_q : dec_rm;
    rm_bad  = dyn_sel && (frm_q > RM_LAST_OK);
  end
endmodule

// File: rtl/fpctl_acc_check.sv
module fpctl_acc_check
  import fpctl_pkg::*;
#(
  parameter int NUM_CLASSES = 4,
  parameter bit PROMOTE     = 1'b0,
  localparam int CLS_W  = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1,
  localparam int MASK_W = NUM_CLASSES * ACC_CODES
)(
  input  logic [ACC_W-1:0]  acc_req,
  input  logic [CLS_W-1:0]  cls,
  input  logic [MASK_W-1:0] mask,
  output logic [ACC_W-1:0]  acc_eff,
  output logic              acc_bad
);
  logic [ACC_CODES-1:0] row;

  always_comb begin
    row = '0;
    for (int c = 0; c < NUM_CLASSES; c++) begin
      if (cls == CLS_W'(c)) row = mask[c*ACC_CODES +: ACC_CODES];
    end
  end

  generate
    if (PROMOTE) begin : g_promote
      localparam int IDX_W = ACC_W - 1;
      logic [IDX_W-1:0] req_idx, best_idx;
      logic             found;
      logic [ACC_EVEN-1:0] unused_odd_bits;

      always_comb begin
        for (int j = 0; j < ACC_EVEN; j++) unused_odd_bits[j] = row[2*j+1];
      end

      always_comb begin
        req_idx  = acc_req[ACC_W-1:1];
        best_idx = '0;
        found    = 1'b0;
        for (int j = 0; j < ACC_EVEN; j++) begin
          if ((IDX_W'(j) <= req_idx) && row[2*j]) begin
            best_idx = IDX_W'(j);
            found    = 1'b1;
          end
        end
        acc_bad = acc_req[0] || !found;
        acc_eff = acc_bad ? acc_req : {best_idx, 1'b0};
      end
    end else begin : g_direct
      always_comb begin
        acc_bad = acc_req[0] || !row[acc_req];
        acc_eff = acc_req;
      end
    end
  endgenerate
endmodule

// File: rtl/fpctl_unit.sv
module fpctl_unit
  import fpctl_pkg::*;
#(
  parameter int NUM_CLASSES = 4,
  parameter bit PROMOTE     = 1'b0,
  localparam int CLS_W  = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1,
  localparam int MASK_W = NUM_CLASSES * ACC_CODES
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [1:0]        csr_view,
  input  logic [CSR_W-1:0]  csr_wdata,
  output logic [CSR_W-1:0]  csr_rdata,
  input  logic              flag_valid,
  input  logic [FLAG_W-1:0] flag_bits,
  input  logic              dec_valid,
  input  logic [RM_W-1:0]   dec_rm,
  input  logic [CLS_W-1:0]  dec_cls,
  input  logic [MASK_W-1:0] acc_support_mask,
  output logic [RM_W-1:0]   eff_rm,
  output logic [ACC_W-1:0]  eff_acc,
  output logic              trap
);
  logic [FLAG_W-1:0] flags_q;
  logic [RM_W-1:0]   frm_q;
  logic [ACC_W-1:0]  acc_q;
  logic              rm_bad, acc_bad;
  logic [FLAG_W-1:0] unused_flags;

  assign unused_flags = flags_q;

  fpctl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .csr_we     (csr_we),
    .csr_view   (csr_view_e'(csr_view)),
    .csr_wdata  (csr_wdata),
    .flag_valid (flag_valid),
    .flag_bits  (flag_bits),
    .flags_q    (flags_q),
    .frm_q      (frm_q),
    .acc_q      (acc_q),
    .csr_rdata  (csr_rdata)
  );

  fpctl_round_sel u_round (
    .dec_rm (dec_rm),
    .frm_q  (frm_q),
    .eff_rm (eff_rm),
    .rm_bad (rm_bad)
  );

  fpctl_acc_check #(
    .NUM_CLASSES (NUM_CLASSES),
    .PROMOTE     (PROMOTE)
  ) u_acc (
    .acc_req (acc_q),
    .cls     (dec_cls),
    .mask    (acc_support_mask),
    .acc_eff (eff_acc),
    .acc_bad (acc_bad)
  );

  assign trap = dec_valid && (rm_bad || acc_bad);

  assert_dyn_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_rm == RM_DYNAMIC && frm_q > RM_LAST_OK) |-> trap);

  assert_odd_acc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && acc_q[0]) |-> trap);

  assert_idle_no_trap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !trap);

  assert_static_rm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_rm != RM_DYNAMIC) |-> (eff_rm == dec_rm));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[CSR_W-1:USED_W] == '0);
endmodule

// File: tb/fpctl_unit_test.sv
module fpctl_unit_test;
  logic        clk;
  logic        rst_n;
  logic        csr_we;
  logic [1:0]  csr_view;
  logic [31:0] csr_wdata;
  logic        flag_valid;
  logic [4:0]  flag_bits;
  logic        dec_valid;
  logic [2:0]  dec_rm;
  logic [1:0]  dec_cls;
  logic [31:0] mask_d, mask_p;
  logic [31:0] rdata_d, rdata_p;
  logic [2:0]  rm_d, rm_p, acc_d, acc_p;
  logic        trap_d, trap_p;

  int checks = 0;
  int errors = 0;

  fpctl_unit #(.NUM_CLASSES(4), .PROMOTE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_view(csr_view),
    .csr_wdata(csr_wdata), .csr_rdata(rdata_d), .flag_valid(flag_valid),
    .flag_bits(flag_bits), .dec_valid(dec_valid), .dec_rm(dec_rm),
    .dec_cls(dec_cls), .acc_support_mask(mask_d), .eff_rm(rm_d),
    .eff_acc(acc_d), .trap(trap_d));

  fpctl_unit #(.NUM_CLASSES(4), .PROMOTE(1'b1)) uut_promote (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_view(csr_view),
    .csr_wdata(csr_wdata), .csr_rdata(rdata_p), .flag_valid(flag_valid),
    .flag_bits(flag_bits), .dec_valid(dec_valid), .dec_rm(dec_rm),
    .dec_cls(dec_cls), .acc_support_mask(mask_p), .eff_rm(rm_p),
    .eff_acc(acc_p), .trap(trap_p));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] view, input logic [31:0] data);
    @(negedge clk);
    csr_we = 1'b1; csr_view = view; csr_wdata = data;
    @(negedge clk);
    csr_we = 1'b0; flag_valid = 1'b0;
  endtask

  task automatic rd(input logic [1:0] view, output logic [31:0] val);
    csr_view = view;
    #1;
    val = rdata_d;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'b00, v);
    chk("R1 reset word", v, 32'h0);
    dec_valid = 1'b1; dec_rm = 3'b111; dec_cls = 2'd0; #1;
    chk("R1 reset acc", {29'b0, acc_d}, 32'h0);
    chk("R1 reset rm", {29'b0, rm_d}, 32'h0);
    dec_valid = 1'b0;
  endtask

  task automatic t_whole();
    logic [31:0] v;
    wr(2'b00, 32'hFFFF_FC56);
    rd(2'b00, v);
    chk("R2 whole readback", v, 32'h0000_0456);
    dec_valid = 1'b0; #1;
    chk("R12 eff_acc stored", {29'b0, acc_d}, 32'h4);
  endtask

  task automatic t_round_view();
    logic [31:0] v;
    wr(2'b01, 32'hFFFF_FFF9);
    rd(2'b01, v);
    chk("R3 round view", v, 32'h1);
    rd(2'b00, v);
    chk("R3 other fields kept", v, 32'h436);
  endtask

  task automatic t_flags_view();
    logic [31:0] v;
    wr(2'b10, 32'hFFFF_FFE9);
    rd(2'b10, v);
    chk("R4 flags view", v, 32'h09);
    rd(2'b00, v);
    chk("R4 other fields kept", v, 32'h429);
  endtask

  task automatic t_none_view();
    logic [31:0] v;
    rd(2'b11, v);
    chk("R13 none view reads zero", v, 32'h0);
    wr(2'b11, 32'hFFFF_FFFF);
    rd(2'b00, v);
    chk("R13 none view write ignored", v, 32'h429);
  endtask

  task automatic t_accum();
    logic [31:0] v;
    wr(2'b00, 32'h0);
    @(negedge clk); flag_valid = 1'b1; flag_bits = 5'b00101;
    @(negedge clk); flag_bits = 5'b10001;
    @(negedge clk); flag_valid = 1'b0;
    rd(2'b10, v);
    chk("R5 accumulate", v, 32'h15);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    @(negedge clk);
    csr_we = 1'b1; csr_view = 2'b10; csr_wdata = 32'h02;
    flag_valid = 1'b1; flag_bits = 5'b01000;
    @(negedge clk);
    csr_we = 1'b0; flag_valid = 1'b0;
    rd(2'b10, v);
    chk("R6 write beats accumulate", v, 32'h02);
    @(negedge clk);
    csr_we = 1'b1; csr_view = 2'b01; csr_wdata = 32'h3;
    flag_valid = 1'b1; flag_bits = 5'b10000;
    @(negedge clk);
    csr_we = 1'b0; flag_valid = 1'b0;
    rd(2'b00, v);
    chk("R6 round write keeps accumulate", v, 32'h72);
  endtask

  task automatic t_rounding();
    dec_valid = 1'b1; dec_cls = 2'd0;
    dec_rm = 3'b111; #1;
    chk("R7 dynamic rm", {29'b0, rm_d}, 32'h3);
    chk("R8 valid dynamic no trap", {31'b0, trap_d}, 32'h0);
    dec_rm = 3'b001; #1;
    chk("R7 static rm", {29'b0, rm_d}, 32'h1);
    for (int m = 5; m < 8; m++) begin
      wr(2'b01, 32'(m));
      dec_rm = 3'b111; #1;
      chk("R8 invalid dynamic traps", {31'b0, trap_d}, 32'h1);
      dec_rm = 3'b010; #1;
      chk("R8 static no trap", {31'b0, trap_d}, 32'h0);
      chk("R7 static rm passes", {29'b0, rm_d}, 32'h2);
      dec_rm = 3'b101; #1;
      chk("R8 static 101 no trap", {31'b0, trap_d}, 32'h0);
    end
    dec_rm = 3'b111; dec_valid = 1'b0; #1;
    chk("R12 idle no trap", {31'b0, trap_d}, 32'h0);
    wr(2'b01, 32'h0);
  endtask

  task automatic t_acc_direct();
    logic expt;
    dec_rm = 3'b000;
    for (int a = 0; a < 8; a++) begin
      wr(2'b00, 32'(a) << 8);
      for (int c = 0; c < 4; c++) begin
        dec_valid = 1'b1; dec_cls = 2'(c); #1;
        expt = (a % 2 == 1) || !mask_d[c*8+a];
        if (a % 2 == 1) chk("R10 odd acc traps", {31'b0, trap_d}, {31'b0, expt});
        else            chk("R9 support mask", {31'b0, trap_d}, {31'b0, expt});
        chk("R12 eff_acc direct", {29'b0, acc_d}, 32'(a));
        dec_valid = 1'b0; #1;
        chk("R12 no trap when idle", {31'b0, trap_d}, 32'h0);
      end
    end
  endtask

  task automatic pchk(input int cls, input int a, input logic et, input int ea);
    wr(2'b00, 32'(a) << 8);
    dec_valid = 1'b1; dec_rm = 3'b000; dec_cls = 2'(cls); #1;
    chk("R11 promote trap", {31'b0, trap_p}, {31'b0, et});
    if (!et) chk("R11 promote eff_acc", {29'b0, acc_p}, 32'(ea));
    dec_valid = 1'b0;
  endtask

  task automatic t_promote();
    pchk(1, 0, 1'b1, 0);
    pchk(1, 2, 1'b1, 0);
    pchk(1, 6, 1'b0, 6);
    pchk(2, 2, 1'b0, 0);
    pchk(2, 6, 1'b0, 4);
    pchk(3, 4, 1'b0, 2);
    pchk(3, 6, 1'b0, 2);
    pchk(0, 4, 1'b0, 4);
    pchk(0, 3, 1'b1, 0);
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; csr_we = 1'b0; csr_view = 2'b00; csr_wdata = '0;
    flag_valid = 1'b0; flag_bits = '0; dec_valid = 1'b0; dec_rm = '0;
    dec_cls = '0;
    mask_d = 32'h07_11_01_55;
    mask_p = 32'h07_11_40_55;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_whole();
    t_round_view();
    t_flags_view();
    t_none_view();
    t_accum();
    t_priority();
    t_rounding();
    t_acc_direct();
    t_promote();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule